// File: doc/BRIEF.md
# Port Speed and Activity Indicator

This block drives the two indicator outputs that belong to one network port. The speed indicator shows which line rate is present on the port: 100 Mb/s or 10 Mb/s. Idle symbols count as well as packets. When neither rate is present, the speed indicator is released to high impedance.

The activity indicator has two meanings, and the state of the speed indicator picks between them. While the speed indicator is released, the activity indicator is pulled low while auto-negotiation bursts arrive. While the speed indicator is driven, the activity indicator is pulled low for detected packets. Each packet indication is stretched so that the light stays visible for a minimum time. A free-running prescaler produces a periodic tick, and a stretch lasts until two ticks have passed. A test-fast flag shortens the tick period.

Each output is a value and output-enable pair, which the pad logic turns into a tri-state pin. For test purposes, either output can be forced to a test value.

Top module: `port_led_ind`

## Requirements
- R1: When `sig100_i` is 1, the speed output is driven high (`spd_oe_o`=1, `spd_o`=1). This holds even when `sig10_i` is also 1.
- R2: When only `sig10_i` is 1, the speed output is driven low (`spd_oe_o`=1, `spd_o`=0).
- R3: When neither rate flag is set, `spd_oe_o`=0 and `spd_o`=0.
- R4: When no rate flag is set, the activity output follows `aneg_rx_i`: `act_oe_o`=1 and `act_o`=0 while it is 1, and `act_oe_o`=0 otherwise. Whenever the activity output is not overridden, `act_o` is 0.
- R5: When a rate flag is set, `aneg_rx_i` has no effect. A `pkt_i` strobe drives the activity output low in the same cycle as the strobe.
- R6: With `test_fast_i`=0, a single-cycle strobe keeps the activity output low for the strobe cycle plus between NORM_DIV+1 and 2*NORM_DIV further cycles.
- R7: With `test_fast_i`=1, the same window applies with FAST_DIV in place of NORM_DIV.
- R8: A strobe that arrives during an active stretch restarts the stretch from that strobe.
- R9: A strobe seen while no rate flag is set is ignored. Losing the rate flags clears any stretch in progress, so that the activity output is not driven when a rate flag returns.
- R10: Bit 0 of `test_en_i` forces the speed output to be driven with `test_val_i[0]`. Bit 1 of `test_en_i` forces the activity output to be driven with `test_val_i[1]`. An output whose enable bit is 0 behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig100_i | input | 1 | 100 Mb/s signal present |
| sig10_i | input | 1 | 10 Mb/s signal present |
| aneg_rx_i | input | 1 | Auto-negotiation bursts being received |
| pkt_i | input | 1 | Packet detected strobe |
| test_fast_i | input | 1 | Shortened stretch timing |
| test_en_i | input | 2 | Per-output test override enable (bit 0 speed, bit 1 activity) |
| test_val_i | input | 2 | Per-output test value |
| spd_o | output | 1 | Speed indicator value |
| spd_oe_o | output | 1 | Speed indicator output enable |
| act_o | output | 1 | Activity indicator value |
| act_oe_o | output | 1 | Activity indicator output enable |

## Verification
The bench sends strobes at several prescaler phases and measures each stretch against the two-tick window, in both timing modes. A design that counts only one tick, or that ignores the fast flag, produces widths outside the window. It then sends a second strobe late in a stretch. A design that does not restart ends too early. Strobes while no rate is present, and a loss of the rate flags in the middle of a stretch, catch a design that keeps stale stretch state and lights the activity output when the link returns. The bench also sets both rate flags together and sets auto-negotiation during data, which catches wrong priority and wrong choice of meaning.

// File: rtl/port_led_ind.sv
module port_led_ind #(
  parameter int unsigned NORM_DIV   = 32500,
  parameter int unsigned FAST_DIV   = 4075,
  parameter int unsigned HOLD_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig100_i,
  input  logic       sig10_i,
  input  logic       aneg_rx_i,
  input  logic       pkt_i,
  input  logic       test_fast_i,
  input  logic [1:0] test_en_i,
  input  logic [1:0] test_val_i,
  output logic       spd_o,
  output logic       spd_oe_o,
  output logic       act_o,
  output logic       act_oe_o
);
  localparam int CW = $clog2(NORM_DIV + 1);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [CW-1:0] pre_q;
  logic [HW-1:0] hold_q;

  wire [CW-1:0] lim     = test_fast_i ? CW'(FAST_DIV - 1) : CW'(NORM_DIV - 1);
  wire          tick    = pre_q >= lim;
  wire          data_up = sig100_i | sig10_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hold_q <= '0;
    else if (!data_up)              hold_q <= '0;
    else if (pkt_i)                 hold_q <= HW'(HOLD_TICKS);
    else if (tick && hold_q != '0)  hold_q <= hold_q - 1'b1;
  end

  wire pkt_lit = pkt_i | (hold_q != '0);
  wire act_lit = data_up ? pkt_lit : aneg_rx_i;

  assign spd_oe_o = test_en_i[0] | data_up;
  assign spd_o    = test_en_i[0] ? test_val_i[0] : sig100_i;
  assign act_oe_o = test_en_i[1] | act_lit;
  assign act_o    = test_en_i[1] & test_val_i[1];
endmodule

// File: rtl/port_led_ind_chk.sv
module port_led_ind_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sig100_i,
  input logic       sig10_i,
  input logic       aneg_rx_i,
  input logic       pkt_i,
  input logic [1:0] test_en_i,
  input logic [1:0] test_val_i,
  input logic       spd_o,
  input logic       spd_oe_o,
  input logic       act_o,
  input logic       act_oe_o
);
  // R1
  spd_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sig100_i && !test_en_i[0]) |-> (spd_oe_o && spd_o));
  // R2
  spd_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sig10_i && !sig100_i && !test_en_i[0]) |-> (spd_oe_o && !spd_o));
  // R3
  spd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sig10_i && !sig100_i && !test_en_i[0]) |-> !spd_oe_o);
  // R4
  act_aneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sig10_i && !sig100_i && !test_en_i[1]) |-> (act_oe_o == aneg_rx_i && !act_o));
  // R5
  act_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sig10_i || sig100_i) && pkt_i && !test_en_i[1]) |-> (act_oe_o && !act_o));
  // R6
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sig10_i || sig100_i) && pkt_i) ##1 ((sig10_i || sig100_i) && !test_en_i[1]) |-> act_oe_o);
  // R10
  act_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_en_i[1] |-> (act_oe_o && act_o == test_val_i[1]));
  // R10
  spd_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_en_i[0] |-> (spd_oe_o && spd_o == test_val_i[0]));
endmodule

bind port_led_ind port_led_ind_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sig100_i(sig100_i), .sig10_i(sig10_i),
  .aneg_rx_i(aneg_rx_i), .pkt_i(pkt_i), .test_en_i(test_en_i),
  .test_val_i(test_val_i), .spd_o(spd_o), .spd_oe_o(spd_oe_o),
  .act_o(act_o), .act_oe_o(act_oe_o));

// File: tb/tb_port_led_ind.sv
module tb_port_led_ind;
  localparam int CLK_PERIOD = 10;
  localparam int NDIV = 40;
  localparam int FDIV = 8;

  logic clk = 0, rst_n = 0;
  logic sig100 = 0, sig10 = 0, aneg = 0, pkt = 0, tfast = 0;
  logic [1:0] ten = 0, tval = 0;
  logic spd, spd_oe, act, act_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  port_led_ind #(.NORM_DIV(NDIV), .FAST_DIV(FDIV)) dut (
    .clk(clk), .rst_n(rst_n), .sig100_i(sig100), .sig10_i(sig10),
    .aneg_rx_i(aneg), .pkt_i(pkt), .test_fast_i(tfast), .test_en_i(ten),
    .test_val_i(tval), .spd_o(spd), .spd_oe_o(spd_oe), .act_o(act), .act_oe_o(act_oe));

  task automatic check(bit ok, string tag, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  // exp = {spd_oe, spd, act_oe, act}
  task automatic drive(bit s100, bit s10, bit an, bit pk, logic [1:0] te,
                       logic [1:0] tv, logic [3:0] e, string tag);
    @(posedge clk); #1;
    sig100 = s100; sig10 = s10; aneg = an; pkt = pk; ten = te; tval = tv;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({spd_oe, spd, act_oe, act} == e, t, {spd_oe, spd, act_oe, act}, e);
    end
  end

  // single-cycle strobe, count lit negedge samples
  task automatic strobe_width(output int w, input int second_at);
    w = 0;
    @(posedge clk); #1; pkt = 1;
    @(negedge clk);
    if (act_oe && !act) w++;
    @(posedge clk); #1; pkt = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!(act_oe && !act)) break;
      w++;
      if (w == second_at) begin
        @(posedge clk); #1; pkt = 1;
        @(negedge clk);
        if (act_oe && !act) w++;
        @(posedge clk); #1; pkt = 0;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int w;
    #(CLK_PERIOD * 3); rst_n = 1;
    @(negedge clk);
    check({spd_oe, spd, act_oe, act} == 4'b0000, "R3 reset", {spd_oe, spd, act_oe, act}, 0);

    drive(0, 0, 0, 0, 0, 0, 4'b0000, "R3 idle");
    drive(0, 0, 1, 0, 0, 0, 4'b0010, "R4 aneg");
    drive(1, 0, 0, 0, 0, 0, 4'b1100, "R1 100");
    drive(1, 1, 0, 0, 0, 0, 4'b1100, "R1 both");
    drive(0, 1, 0, 0, 0, 0, 4'b1000, "R2 10");
    drive(0, 1, 1, 0, 0, 0, 4'b1000, "R5 aneg ignored");
    drive(0, 0, 0, 1, 0, 0, 4'b0000, "R9 pkt no link");
    drive(1, 0, 0, 0, 0, 0, 4'b1100, "R9 no stale stretch");
    drive(1, 0, 0, 1, 0, 0, 4'b1110, "R5 pkt same cycle");
    drive(1, 0, 0, 0, 0, 0, 4'b1110, "R6 held");
    drive(0, 0, 0, 0, 0, 0, 4'b0000, "R9 link loss");
    drive(1, 0, 0, 0, 0, 0, 4'b1100, "R9 cleared");
    drive(0, 0, 0, 0, 2'b01, 2'b01, 4'b1100, "R10 spd force hi");
    drive(1, 0, 0, 0, 2'b01, 2'b00, 4'b1000, "R10 spd force lo");
    drive(0, 0, 1, 0, 2'b10, 2'b10, 4'b0011, "R10 act force hi");
    drive(0, 1, 0, 0, 2'b10, 2'b00, 4'b1010, "R10 act force lo");
    drive(0, 0, 0, 0, 0, 0, 4'b0000, "R3 back idle");
    @(posedge clk); @(posedge clk);

    sig100 = 1;
    for (int k = 0; k < 4; k++) begin
      repeat (7 + 9 * k) @(posedge clk);
      strobe_width(w, -1);
      check(w >= NDIV + 2 && w <= 2 * NDIV + 1, "R6 width", w, NDIV + 2);
    end
    strobe_width(w, NDIV);
    check(w >= 2 * NDIV + 2 && w <= 3 * NDIV + 1, "R8 restart", w, 2 * NDIV + 2);

    tfast = 1;
    repeat (3 * NDIV) @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      repeat (3 + k) @(posedge clk);
      strobe_width(w, -1);
      check(w >= FDIV + 2 && w <= 2 * FDIV + 1, "R7 fast width", w, FDIV + 2);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule